// File: doc/BRIEF.md
# SPI Command Register Interface

This block is an SPI target that collects fixed 32-bit frames from a master and turns them into register writes, register reads or a drive-mode command for a dot-matrix display driver. Every SPI pin is brought into the system clock domain through two-flop synchronisers. Edges of the serial clock and of the select line are detected there, so the system clock must run at least four times faster than the serial clock.

A frame that has been shifted in does nothing on its own. It stays held until the master pulses a separate active-low latch strobe while select is high, and only then is it executed. A read command loads a read buffer at that strobe. The master collects the value on MISO during its next 32-bit frame, which it normally sends as all zeros.

The shift front end has two states. `SH_IDLE` goes to `SH_SHIFT` on a select fall, and that step also loads the transmit register from the read buffer. `SH_SHIFT` returns to `SH_IDLE` on a select rise, and a frame is delivered only when exactly 32 bits were counted. The execution stage has three states. `EX_IDLE` goes to `EX_ARMED` when a frame arrives, or straight to `EX_EXEC` when a strobe arrives in the same cycle. `EX_ARMED` goes to `EX_EXEC` on a strobe. `EX_EXEC` lasts one cycle and applies the frame, then goes to `EX_ARMED` if another frame arrived in that cycle and to `EX_IDLE` otherwise.

Top module: `spi_cmd_regs`

## Requirements
- R1: After reset, the dot pattern, all compare registers, both mode flags, the read buffer and MISO are zero.
- R2: A frame is 32 bits, shifted most significant bit first, with bits 31..24 the opcode, 23..16 the address and 15..0 the data. A select-low period containing any number of rising serial clock edges other than exactly 32 is discarded, and any frame already held is kept.
- R3: Opcode 0x02 writes the data field. Address 0x00 takes data bits 9..0 as the 10-bit dot pattern. Address 0x02+2k takes the data as bits 15..0 of compare register k, and 0x03+2k takes it as bits 31..16, for k = 0..3.
- R4: Nothing changes until a falling latch strobe is seen while select is high. A strobe seen while select is low is ignored. A held frame is executed only once, so a strobe with no frame held has no effect.
- R5: Opcode 0x01 loads the read buffer with the addressed register at the strobe. The dot pattern is zero-extended. The next frame returns the buffer on MISO as bits 15..0 of the 32 bits, with bits 31..16 zero. MISO advances one bit after each falling serial clock edge.
- R6: An opcode of the form 00 p i 1000 (binary) sets the past-state flag to p and the invert flag to i. Its address and data fields are ignored, and no register changes.
- R7: Any other opcode is ignored. A write to an unmapped address (0x01, or 0x0A and above) changes nothing. A read of an unmapped address returns 0.
- R8: If a frame completes in the same cycle as a valid strobe, the strobe executes that new frame. A newer complete frame replaces an older one that has not been executed.
- R9: Registers and flags update on the fourth rising system clock edge, counting from the first edge that samples the latch strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sel_n | input | 1 | Active-low target select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| latch_n | input | 1 | Active-low strobe that executes the held frame |
| dot_pattern | output | 10 | Dot pattern register |
| cmp_flat | output | 128 | Compare registers, register k in bits 32k+31..32k |
| drv_past | output | 1 | Past-state mode flag |
| drv_invert | output | 1 | Invert mode flag |

## Verification
Two things can land in the same cycle: delivery of a completed frame from the shifter, and a latch strobe reaching the execution stage. The bench provokes this by raising select and lowering the latch strobe at the same clock edge. Both then pass through equal synchroniser delays. A behavioural model expects the new frame, not the older held one, to be applied four edges later. Registers are compared against the model on every clock, so a wrong choice or a slip of one cycle is reported as soon as it happens.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int FRAME_W = 32;
    localparam int DATA_W  = 16;

    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h01;
    localparam logic [3:0] MODE_TAG = 4'h8;

    typedef struct packed {
        logic [7:0]        op;
        logic [7:0]        addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic {
        SH_IDLE,
        SH_SHIFT
    } sh_state_t;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_ARMED,
        EX_EXEC
    } ex_state_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 EDGE_W  = 3,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  async_in,
    output logic [WIDTH-1:0]  level,
    output logic [EDGE_W-1:0] prev
);

    logic [WIDTH-1:0] meta_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                level[b]  <= RST_VAL[b];
            end else begin
                meta_q[b] <= async_in[b];
                level[b]  <= meta_q[b];
            end
        end

        if (b < EDGE_W) begin : g_edge
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev[b] <= RST_VAL[b];
                else        prev[b] <= level[b];
            end
        end
    end

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_W,
    parameter int RD_W       = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  sel_fall,
    input  logic                  sel_rise,
    input  logic                  mosi_bit,
    input  logic [RD_W-1:0]       rd_word,
    output logic                  miso,
    output logic                  frame_ok,
    output logic [FRAME_BITS-1:0] frame_word
);

    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sh_state_t             state, state_nx;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] rx_q;
    logic [FRAME_BITS-1:0] tx_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:  if (sel_fall) state_nx = SH_SHIFT;
            SH_SHIFT: if (sel_rise) state_nx = SH_IDLE;
            default:  state_nx = SH_IDLE;
        endcase
    end

    // Datapath: receive, transmit, bit counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    if (sel_fall) begin
                        bit_cnt <= '0;
                        rx_q    <= '0;
                        tx_q    <= {{(FRAME_BITS-RD_W){1'b0}}, rd_word};
                    end
                end
                SH_SHIFT: begin
                    if (sclk_rise) begin
                        rx_q <= {rx_q[FRAME_BITS-2:0], mosi_bit};
                        if (bit_cnt != CNT_W'(CNT_MAX))
                            bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (sclk_fall)
                        tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        miso       = (state == SH_SHIFT) ? tx_q[FRAME_BITS-1] : 1'b0;
        frame_ok   = (state == SH_SHIFT) && sel_rise &&
                     (bit_cnt == CNT_W'(FRAME_BITS));
        frame_word = rx_q;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_SHIFT && !sclk_rise && !sel_rise) |=> $stable(bit_cnt));

    // R5
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_SHIFT && !sclk_fall && !sel_rise) |=> $stable(miso));

endmodule

// File: rtl/spi_cmd_exec.sv
module spi_cmd_exec
    import spi_cmd_pkg::*;
#(
    parameter int DOT_W    = 10,
    parameter int NCMP     = 4,
    parameter int CMP_BASE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_ok,
    input  logic [FRAME_W-1:0]     frame_word,
    input  logic                   latch_fall,
    input  logic                   sel_high,
    output logic [DOT_W-1:0]       dot_pattern,
    output logic [NCMP*2*DATA_W-1:0] cmp_flat,
    output logic                   drv_past,
    output logic                   drv_invert,
    output logic [DATA_W-1:0]      rd_word
);

    localparam int CMP_W = 2 * DATA_W;

    ex_state_t state, state_nx;
    frame_t    held_q;
    logic      strobe;
    logic      is_write, is_read, is_mode;
    logic [DATA_W-1:0]             rd_val;
    logic [NCMP-1:0][DATA_W-1:0]   rd_part;

    assign strobe = latch_fall && sel_high;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            EX_IDLE:  if (frame_ok) state_nx = strobe ? EX_EXEC : EX_ARMED;
            EX_ARMED: if (strobe)   state_nx = EX_EXEC;
            EX_EXEC:  state_nx = frame_ok ? EX_ARMED : EX_IDLE;
            default:  state_nx = EX_IDLE;
        endcase
    end

    // Held frame: the newest complete frame always wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= '0;
        else if (frame_ok) held_q <= frame_t'(frame_word);
    end

    // Decode of the held frame, used only in EX_EXEC
    always_comb begin
        is_write = (state == EX_EXEC) && (held_q.op == OP_WRITE);
        is_read  = (state == EX_EXEC) && (held_q.op == OP_READ);
        is_mode  = (state == EX_EXEC) && (held_q.op[7:6] == 2'b00) &&
                   (held_q.op[3:0] == MODE_TAG);
    end

    // Dot pattern register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dot_pattern <= '0;
        else if (is_write && held_q.addr == 8'h00)
            dot_pattern <= held_q.data[DOT_W-1:0];
    end

    // Compare registers, one low and one high half each
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        localparam logic [7:0] LO_A = 8'(CMP_BASE + 2 * k);
        localparam logic [7:0] HI_A = 8'(CMP_BASE + 2 * k + 1);
        logic [CMP_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (is_write) begin
                if (held_q.addr == LO_A) q[DATA_W-1:0]     <= held_q.data;
                if (held_q.addr == HI_A) q[CMP_W-1:DATA_W] <= held_q.data;
            end
        end

        assign cmp_flat[k*CMP_W +: CMP_W] = q;
        assign rd_part[k] = (held_q.addr == LO_A) ? q[DATA_W-1:0] :
                            (held_q.addr == HI_A) ? q[CMP_W-1:DATA_W] :
                            '0;
    end

    // Read value mux, zero for unmapped addresses
    always_comb begin
        rd_val = (held_q.addr == 8'h00) ?
                 {{(DATA_W-DOT_W){1'b0}}, dot_pattern} : '0;
        for (int k = 0; k < NCMP; k++)
            rd_val = rd_val | rd_part[k];
    end

    // Read buffer and mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word    <= '0;
            drv_past   <= 1'b0;
            drv_invert <= 1'b0;
        end else begin
            if (is_read) rd_word <= rd_val;
            if (is_mode) begin
                drv_past   <= held_q.op[5];
                drv_invert <= held_q.op[4];
            end
        end
    end

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != EX_EXEC) |=> ($stable(dot_pattern) && $stable(cmp_flat) &&
                                $stable(drv_past) && $stable(drv_invert)));

    // R5
    rdbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != EX_EXEC) |=> $stable(rd_word));

    // R4
    exec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EX_EXEC) |=> (state != EX_EXEC));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DOT_W    = 10,
    parameter int NCMP     = 4,
    parameter int CMP_BASE = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_sclk,
    input  logic                      spi_sel_n,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    input  logic                      latch_n,
    output logic [DOT_W-1:0]          dot_pattern,
    output logic [NCMP*2*DATA_W-1:0]  cmp_flat,
    output logic                      drv_past,
    output logic                      drv_invert
);

    // bit 0 sclk, bit 1 select, bit 2 latch, bit 3 mosi
    localparam int SYNC_W = 4;
    localparam int EDGE_W = 3;

    logic [SYNC_W-1:0] lvl;
    logic [EDGE_W-1:0] prv;
    logic sclk_rise, sclk_fall, sel_rise, sel_fall, latch_fall;
    logic frame_ok;
    logic [FRAME_W-1:0] frame_word;
    logic [DATA_W-1:0]  rd_word;

    spi_cmd_sync #(
        .WIDTH   (SYNC_W),
        .EDGE_W  (EDGE_W),
        .RST_VAL (4'b0110)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_mosi, latch_n, spi_sel_n, spi_sclk}),
        .level    (lvl),
        .prev     (prv)
    );

    assign sclk_rise  =  lvl[0] & ~prv[0];
    assign sclk_fall  = ~lvl[0] &  prv[0];
    assign sel_rise   =  lvl[1] & ~prv[1];
    assign sel_fall   = ~lvl[1] &  prv[1];
    assign latch_fall = ~lvl[2] &  prv[2];

    spi_cmd_shifter #(
        .FRAME_BITS (FRAME_W),
        .RD_W       (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sel_fall   (sel_fall),
        .sel_rise   (sel_rise),
        .mosi_bit   (lvl[3]),
        .rd_word    (rd_word),
        .miso       (spi_miso),
        .frame_ok   (frame_ok),
        .frame_word (frame_word)
    );

    spi_cmd_exec #(
        .DOT_W    (DOT_W),
        .NCMP     (NCMP),
        .CMP_BASE (CMP_BASE)
    ) u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok    (frame_ok),
        .frame_word  (frame_word),
        .latch_fall  (latch_fall),
        .sel_high    (lvl[1]),
        .dot_pattern (dot_pattern),
        .cmp_flat    (cmp_flat),
        .drv_past    (drv_past),
        .drv_invert  (drv_invert),
        .rd_word     (rd_word)
    );

endmodule

// File: tb/sim_spi_cmd_regs.sv
`timescale 1ns/1ps
module sim_spi_cmd_regs;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0, latch_n = 1'b1;
    logic miso;
    logic [9:0]   dot_pattern;
    logic [127:0] cmp_flat;
    logic drv_past, drv_invert;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [9:0]  m_pat = '0;
    logic [31:0] m_cmp [4] = '{default: '0};
    logic        m_past = 0, m_inv = 0;
    logic [15:0] m_rd = '0;
    logic        m_pv = 0;
    logic [31:0] m_pend = '0;
    int          cd = 0;

    always #2 clk = ~clk;

    spi_cmd_regs u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sel_n(sel_n),
        .spi_mosi(mosi), .spi_miso(miso), .latch_n(latch_n),
        .dot_pattern(dot_pattern), .cmp_flat(cmp_flat),
        .drv_past(drv_past), .drv_invert(drv_invert)
    );

    function automatic logic [15:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return {6'b0, m_pat};
        if (a >= 8'h02 && a <= 8'h09)
            return a[0] ? m_cmp[(a - 2) / 2][31:16] : m_cmp[(a - 2) / 2][15:0];
        return 16'h0;
    endfunction

    task automatic m_apply(input logic [31:0] f);
        logic [7:0] op, a;
        logic [15:0] d;
        op = f[31:24]; a = f[23:16]; d = f[15:0];
        if (op == 8'h02) begin
            if (a == 8'h00) m_pat = d[9:0];
            else if (a >= 8'h02 && a <= 8'h09) begin
                if (a[0]) m_cmp[(a - 2) / 2][31:16] = d;
                else      m_cmp[(a - 2) / 2][15:0]  = d;
            end
        end else if (op == 8'h01) begin
            m_rd = m_read(a);
        end else if (op[7:6] == 2'b00 && op[3:0] == 4'h8) begin
            m_past = op[5]; m_inv = op[4];
        end
    endtask

    // R9: execution lands on the fourth edge after the strobe is driven
    always @(posedge clk) begin
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0 && m_pv) begin
                m_apply(m_pend);
                m_pv = 0;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dot_pattern !== m_pat) begin
                fails++;
                $display("FAIL R3/R9 pattern actual=%h expected=%h t=%0t", dot_pattern, m_pat, $time);
            end
            checks++;
            if (cmp_flat !== {m_cmp[3], m_cmp[2], m_cmp[1], m_cmp[0]}) begin
                fails++;
                $display("FAIL R3/R9 compare actual=%h expected=%h t=%0t", cmp_flat,
                         {m_cmp[3], m_cmp[2], m_cmp[1], m_cmp[0]}, $time);
            end
            checks++;
            if ({drv_past, drv_invert} !== {m_past, m_inv}) begin
                fails++;
                $display("FAIL R6 flags actual=%b expected=%b t=%0t", {drv_past, drv_invert},
                         {m_past, m_inv}, $time);
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] f, input int nbits, input bit with_latch,
                        output logic [31:0] rx);
        rx = '0;
        @(negedge clk);
        sel_n = 0; sclk = 0;
        clks(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? f[31 - i] : 1'b0;
            clks(4);
            rx = {rx[30:0], miso};
            sclk = 1;
            clks(4);
            sclk = 0;
        end
        clks(4);
        sel_n = 1;
        if (nbits == 32) begin m_pend = f; m_pv = 1; end
        if (with_latch) begin latch_n = 0; cd = 4; end
        clks(6);
        latch_n = 1;
        clks(6);
    endtask

    task automatic strobe();
        @(negedge clk);
        latch_n = 0;
        if (sel_n) cd = 4;
        clks(6);
        latch_n = 1;
        clks(6);
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] a, input logic [15:0] d);
        logic [31:0] rx;
        send({op, a, d}, 32, 0, rx);
        strobe();
    endtask

    // R5 read through the next frame
    task automatic rd_check(input logic [7:0] a, input logic [15:0] exp);
        logic [31:0] rx;
        send({8'h01, a, 16'h0}, 32, 0, rx);
        strobe();
        send(32'h0, 32, 0, rx);
        checks++;
        if (rx !== {16'h0, exp} || m_rd !== exp) begin
            fails++;
            $display("FAIL R5 read addr=%h actual=%h expected=%h", a, rx, {16'h0, exp});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rx;
        clks(5);
        rst_n = 1;
        clks(3);
        // R1 reset state
        checks++;
        if (miso !== 1'b0 || dot_pattern !== '0 || cmp_flat !== '0 || drv_past || drv_invert) begin
            fails++;
            $display("FAIL R1 reset actual=%b%h%h expected=0", miso, dot_pattern, cmp_flat);
        end
        rd_check(8'h00, 16'h0000);                 // R1 read buffer zero

        // R3 writes, R4 nothing before strobe (per-clock model)
        wr(8'h02, 8'h00, 16'hFFFF);
        wr(8'h02, 8'h02, 16'h0004);
        wr(8'h02, 8'h03, 16'h1234);
        wr(8'h02, 8'h04, 16'h000F);
        wr(8'h02, 8'h05, 16'hA5C3);
        wr(8'h02, 8'h06, 16'h0080);
        wr(8'h02, 8'h09, 16'hBEEF);
        rd_check(8'h00, 16'h03FF);                 // R5 zero-extended pattern
        rd_check(8'h05, 16'hA5C3);
        rd_check(8'h09, 16'hBEEF);
        rd_check(8'h02, 16'h0004);

        // R7 unknown opcode, unmapped addresses
        wr(8'h03, 8'h02, 16'h7777);
        wr(8'h02, 8'h01, 16'h5555);
        wr(8'h02, 8'h0A, 16'h5555);
        wr(8'h02, 8'hFF, 16'h5555);
        rd_check(8'h0A, 16'h0000);
        rd_check(8'h01, 16'h0000);

        // R6 mode commands, address and data ignored
        wr(8'h38, 8'h02, 16'hFFFF);
        wr(8'h18, 8'h00, 16'h0000);
        wr(8'h28, 8'h00, 16'h1111);

        // R2 short and long frames are dropped, held frame kept
        send({8'h02, 8'h00, 16'h0155}, 32, 0, rx);
        send({8'h02, 8'h00, 16'h00AA}, 31, 0, rx);
        send({8'h02, 8'h00, 16'h00AA}, 33, 0, rx);
        strobe();
        checks++;
        if (dot_pattern !== 10'h155) begin
            fails++;
            $display("FAIL R2 pattern actual=%h expected=155", dot_pattern);
        end

        // R4 second strobe without a frame, strobe while select is low
        strobe();
        send({8'h02, 8'h00, 16'h0222}, 32, 0, rx);
        @(negedge clk); sel_n = 0;
        clks(3); latch_n = 0;
        clks(6); latch_n = 1;
        clks(6); sel_n = 1;
        clks(6);
        checks++;
        if (dot_pattern !== 10'h155) begin
            fails++;
            $display("FAIL R4 pattern actual=%h expected=155", dot_pattern);
        end
        strobe();

        // R8 replacement, then frame end and strobe in the same cycle
        send({8'h02, 8'h06, 16'h1111}, 32, 0, rx);
        send({8'h02, 8'h06, 16'h2222}, 32, 0, rx);
        strobe();
        send({8'h02, 8'h07, 16'h3333}, 32, 0, rx);
        send({8'h02, 8'h07, 16'h4444}, 32, 1, rx);
        clks(4);
        checks++;
        if (cmp_flat[95:64] !== 32'h4444_2222) begin
            fails++;
            $display("FAIL R8 compare2 actual=%h expected=44442222", cmp_flat[95:64]);
        end
        rd_check(8'h07, 16'h4444);

        clks(10);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule